// File: doc/BRIEF.md
# Programmable Ordered Set Detector

This block sits behind a biphase-mark receiver that has already turned line activity into 5-bit symbols. While the receiver reports that it is in the preamble phase, the detector keeps the four most recent symbols in a window and compares that window with each of nine 20-bit targets. Seven targets are fixed: three start-of-packet variants, two debug start-of-packet variants, and the hard and cable reset sequences. The other two targets come from run-time configuration inputs. When a comparison succeeds, the block raises a one-cycle detect pulse and gives the number of the matching set.

After a match the detector disarms. It stays silent until the message layer pulses the re-arm input, which happens at end of message or when the receiver restarts. When the preamble flag drops, the window empties, so a sequence cut short by an idle line is never completed by symbols that arrive later.

Top module: `ordered_set_detector`

## Requirements
- R1: During and after reset, `detect_o` is 0, `set_id_o` is 0, and the detector is armed.
- R2: A symbol enters the window only in a cycle where `sym_valid_i` and `preamble_i` are both high. The first symbol of a four-symbol sequence ends up in window bits [19:15] and the last in bits [4:0]. A match is reported in the clock cycle after the strobe that completes it.
- R3: The fixed targets and their identifiers are listed below, with symbols in transmission order. The symbol codes are A=5'b11000, B=5'b10001, C=5'b00110, D=5'b00111 and E=5'b11001.
  - 1: A A A B
  - 2: A A C C
  - 3: A C A C
  - 4: D D D E
  - 5: D A D C
  - 6: A E E C
  - 7: A E C B
- R4: `ext1_pattern_i` matches as identifier 8 and `ext2_pattern_i` matches as identifier 9. Both are packed first-symbol-high, in the same way as the window.
- R5: The search slides one symbol at a time, so a target is found after any number of leading symbols that do not match.
- R6: A match needs four symbols accepted since the window was last cleared. A target whose upper bits are zero never matches a partly filled window.
- R7: After a match, no further detect occurs until `rearm_i` is pulsed. The pulse re-arms the detector and empties the window.
- R8: While `preamble_i` is low, the window is emptied. Symbols received before the drop never combine with symbols received after it.
- R9: If several targets equal the window, the lowest identifier is reported.
- R10: `detect_o` is never high for two consecutive cycles. `set_id_o` is 0 whenever `detect_o` is 0.
- R11: A change on `sym_i` while `sym_valid_i` is low has no effect on the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sym_valid_i | input | 1 | One-cycle strobe marking a new decoded symbol |
| sym_i | input | 5 | Decoded symbol |
| preamble_i | input | 1 | Receiver is in the preamble / ordered-set search phase |
| rearm_i | input | 1 | Re-arms the detector and empties the window |
| ext1_pattern_i | input | 20 | First run-time target, first symbol in bits [19:15] |
| ext2_pattern_i | input | 20 | Second run-time target, first symbol in bits [19:15] |
| detect_o | output | 1 | One-cycle pulse on a match |
| set_id_o | output | 4 | Identifier of the matched set, 0 when idle |

## Verification
The case hardest to reach from the ports is a window that is only partly filled but still looks like a target. The leftover zero bits can coincide with a target, and half a sequence can sit in the window when the preamble drops. The bench reaches this by setting a run-time target whose first three symbols are zero and then sending its single last symbol straight after a re-arm. It also breaks a start-of-packet sequence with a preamble drop before sending the final symbol. Priority is exercised by loading run-time targets that duplicate a fixed set and that duplicate each other.

// File: rtl/osd_pkg.sv
package osd_pkg;

  localparam int unsigned SYM_W    = 5;
  localparam int unsigned WIN_SYMS = 4;
  localparam int unsigned WIN_W    = SYM_W * WIN_SYMS;
  localparam int unsigned N_FIXED  = 7;
  localparam int unsigned N_EXT    = 2;
  localparam int unsigned N_TGT    = N_FIXED + N_EXT;

  localparam logic [SYM_W-1:0] K_SYNC1 = 5'b11000;
  localparam logic [SYM_W-1:0] K_SYNC2 = 5'b10001;
  localparam logic [SYM_W-1:0] K_SYNC3 = 5'b00110;
  localparam logic [SYM_W-1:0] K_RST1  = 5'b00111;
  localparam logic [SYM_W-1:0] K_RST2  = 5'b11001;

  // First transmitted symbol lands in the top bits of the window.
  function automatic logic [WIN_W-1:0] pack4(input logic [SYM_W-1:0] s0,
                                             input logic [SYM_W-1:0] s1,
                                             input logic [SYM_W-1:0] s2,
                                             input logic [SYM_W-1:0] s3);
    return {s0, s1, s2, s3};
  endfunction

  // Fixed target for identifier n (1..N_FIXED).
  function automatic logic [WIN_W-1:0] fixed_target(input int unsigned n);
    case (n)
      1:       return pack4(K_SYNC1, K_SYNC1, K_SYNC1, K_SYNC2);
      2:       return pack4(K_SYNC1, K_SYNC1, K_SYNC3, K_SYNC3);
      3:       return pack4(K_SYNC1, K_SYNC3, K_SYNC1, K_SYNC3);
      4:       return pack4(K_RST1,  K_RST1,  K_RST1,  K_RST2);
      5:       return pack4(K_RST1,  K_SYNC1, K_RST1,  K_SYNC3);
      6:       return pack4(K_SYNC1, K_RST2,  K_RST2,  K_SYNC3);
      7:       return pack4(K_SYNC1, K_RST2,  K_SYNC3, K_SYNC2);
      default: return '0;
    endcase
  endfunction

  // Mask of the targets ranked above identifier id (lower numbers).
  function automatic logic [N_TGT-1:0] higher_rank_mask(input int unsigned id);
    logic [N_TGT-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < N_TGT; i++) begin
      if (i + 1 < id) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/osd_window.sv
module osd_window #(
  parameter int unsigned SYM_W    = osd_pkg::SYM_W,
  parameter int unsigned WIN_SYMS = osd_pkg::WIN_SYMS,
  localparam int unsigned WIN_W   = SYM_W * WIN_SYMS,
  localparam int unsigned CNT_W   = $clog2(WIN_SYMS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic [WIN_W-1:0] win_next_o,
  output logic             ready_o
);

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] fill_q;

  assign win_next_o = {win_q[WIN_W-SYM_W-1:0], sym_i};
  assign ready_o    = (fill_q >= CNT_W'(WIN_SYMS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (clear_i) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (shift_i) begin
      win_q <= win_next_o;
      if (fill_q < CNT_W'(WIN_SYMS)) fill_q <= fill_q + 1'b1;
    end
  end

  assert_clear_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (fill_q == '0));

  assert_fill_bounded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= CNT_W'(WIN_SYMS));

  assert_hold_without_shift_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !clear_i) |=> $stable(win_q));

endmodule

// File: rtl/osd_match.sv
module osd_match #(
  parameter int unsigned WIN_W = osd_pkg::WIN_W,
  parameter int unsigned N_TGT = osd_pkg::N_TGT,
  parameter int unsigned ID_W  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [WIN_W-1:0]            win_i,
  input  logic [N_TGT-1:0][WIN_W-1:0] targets_i,
  output logic                        hit_o,
  output logic [ID_W-1:0]             id_o
);

  logic [N_TGT-1:0] eq;

  for (genvar g = 0; g < N_TGT; g++) begin : g_cmp
    assign eq[g] = (win_i == targets_i[g]);
  end

  // Scan from the highest identifier down so the lowest one overrides.
  always_comb begin
    id_o = '0;
    for (int i = N_TGT - 1; i >= 0; i--) begin
      if (eq[i]) id_o = ID_W'(i + 1);
    end
  end

  assign hit_o = |eq;

  assert_lowest_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((eq & osd_pkg::higher_rank_mask(32'(id_o))) == '0));

  assert_hit_has_id_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (id_o != '0));

endmodule

// File: rtl/ordered_set_detector.sv
module ordered_set_detector #(
  parameter int unsigned ID_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sym_valid_i,
  input  logic [osd_pkg::SYM_W-1:0] sym_i,
  input  logic                      preamble_i,
  input  logic                      rearm_i,
  input  logic [osd_pkg::WIN_W-1:0] ext1_pattern_i,
  input  logic [osd_pkg::WIN_W-1:0] ext2_pattern_i,
  output logic                      detect_o,
  output logic [ID_W-1:0]           set_id_o
);
  import osd_pkg::*;

  logic [N_TGT-1:0][WIN_W-1:0] targets;
  logic [WIN_W-1:0]            win_next;
  logic                        win_ready;
  logic                        hit;
  logic [ID_W-1:0]             hit_id;
  logic                        armed_q;
  logic                        win_clear;
  logic                        win_shift;
  logic                        fire;

  for (genvar g = 0; g < N_FIXED; g++) begin : g_fixed
    assign targets[g] = fixed_target(g + 1);
  end
  assign targets[N_FIXED]     = ext1_pattern_i;
  assign targets[N_FIXED + 1] = ext2_pattern_i;

  assign win_clear = rearm_i || !preamble_i;
  assign win_shift = sym_valid_i && preamble_i && armed_q && !rearm_i;
  assign fire      = win_shift && win_ready && hit;

  osd_window #(.SYM_W(SYM_W), .WIN_SYMS(WIN_SYMS)) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (win_clear),
    .shift_i   (win_shift),
    .sym_i     (sym_i),
    .win_next_o(win_next),
    .ready_o   (win_ready)
  );

  osd_match #(.WIN_W(WIN_W), .N_TGT(N_TGT), .ID_W(ID_W)) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .win_i    (win_next),
    .targets_i(targets),
    .hit_o    (hit),
    .id_o     (hit_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b1;
      detect_o <= 1'b0;
      set_id_o <= '0;
    end else begin
      detect_o <= fire;
      set_id_o <= fire ? hit_id : '0;
      if (rearm_i)   armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
    end
  end

  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |=> !detect_o);

  assert_idle_id_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !detect_o |-> (set_id_o == '0));

  assert_disarmed_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !rearm_i) |=> !detect_o);

  assert_detect_disarms_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detect_o && !$past(rearm_i) && !rearm_i) |=> !armed_q);

  assert_no_preamble_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preamble_i |=> !detect_o);

  assert_needs_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> !detect_o);

endmodule

// File: tb/ordered_set_detector_tb.sv
module ordered_set_detector_tb;
  import osd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sym_valid = 1'b0;
  logic [4:0]  sym = '0;
  logic        preamble = 1'b0;
  logic        rearm = 1'b0;
  logic [19:0] ext1 = '0;
  logic [19:0] ext2 = '0;
  logic        detect;
  logic [3:0]  set_id;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  int    exp_id[$];
  int    exp_cyc[$];
  string exp_req[$];

  localparam logic [4:0] A = 5'b11000, B = 5'b10001, C = 5'b00110,
                         D = 5'b00111, E = 5'b11001;

  ordered_set_detector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_i(sym),
    .preamble_i(preamble), .rearm_i(rearm), .ext1_pattern_i(ext1),
    .ext2_pattern_i(ext2), .detect_o(detect), .set_id_o(set_id)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [19:0] pk(input logic [4:0] a, input logic [4:0] b,
                                     input logic [4:0] c, input logic [4:0] d);
    return {a, b, c, d};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: one strobe, then one idle cycle; pushes the expected result.
  task automatic send(input logic [4:0] s, input int eid, input string req);
    @(negedge clk);
    sym_valid = 1'b1;
    sym = s;
    if (eid != 0) begin
      exp_id.push_back(eid);
      exp_cyc.push_back(cyc + 1);
      exp_req.push_back(req);
    end
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic send4(input logic [19:0] p, input int eid, input string req);
    send(p[19:15], 0, req);
    send(p[14:10], 0, req);
    send(p[9:5],   0, req);
    send(p[4:0],   eid, req);
  endtask

  task automatic do_rearm();
    @(negedge clk);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (detect) begin
        if (exp_id.size() == 0) begin
          check(1'b0, {cur_req, " unexpected detect"}, set_id, 0);
        end else begin
          automatic int    eid = exp_id.pop_front();
          automatic int    ecy = exp_cyc.pop_front();
          automatic string erq = exp_req.pop_front();
          check(set_id == 4'(eid), {erq, " id"}, set_id, eid);
          check(cyc == ecy, {erq, " timing"}, cyc, ecy);
        end
      end else if (set_id != 4'd0) begin
        check(1'b0, "R10 id nonzero while idle", set_id, 0);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(detect == 1'b0, "R1 detect in reset", detect, 0);
    check(set_id == 4'd0, "R1 id in reset", set_id, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(detect == 1'b0 && set_id == 4'd0, "R1 after reset", set_id, 0);

    // R1/R2/R3/R5: armed from reset, sliding search through a lead-in
    cur_req = "R5";
    preamble = 1'b1;
    send(A, 0, "R5"); send(A, 0, "R5"); send(A, 0, "R5");
    send(A, 0, "R5"); send(A, 0, "R5");
    send(B, 1, "R5 sop after lead-in");

    // R7: disarmed, a full sequence is ignored
    cur_req = "R7";
    send4(pk(A, A, A, B), 0, "R7");
    repeat (3) @(negedge clk);
    check(exp_id.size() == 0, "R7 silent while disarmed", exp_id.size(), 0);

    // R3: every fixed target
    cur_req = "R3";
    do_rearm(); send4(pk(A, A, A, B), 1, "R3 id1");
    do_rearm(); send4(pk(A, A, C, C), 2, "R3 id2");
    do_rearm(); send4(pk(A, C, A, C), 3, "R3 id3");
    do_rearm(); send4(pk(D, D, D, E), 4, "R3 id4");
    do_rearm(); send4(pk(D, A, D, C), 5, "R3 id5");
    do_rearm(); send4(pk(A, E, E, C), 6, "R3 id6");
    do_rearm(); send4(pk(A, E, C, B), 7, "R3 id7");

    // R4: run-time targets
    cur_req = "R4";
    ext1 = pk(B, C, D, E);
    ext2 = pk(E, D, C, B);
    do_rearm(); send(A, 0, "R4"); send4(ext1, 8, "R4 ext1");
    do_rearm(); send4(ext2, 9, "R4 ext2");

    // R9: duplicates resolve to the lowest identifier
    cur_req = "R9";
    ext1 = pk(A, A, C, C);
    do_rearm(); send4(pk(A, A, C, C), 2, "R9 ext1 equals fixed");
    ext1 = pk(C, C, C, C);
    ext2 = pk(C, C, C, C);
    do_rearm(); send4(pk(C, C, C, C), 8, "R9 ext1 equals ext2");

    // R6: a partly filled window never matches
    cur_req = "R6";
    ext1 = pk(5'd0, 5'd0, 5'd0, B);
    ext2 = pk(5'd0, 5'd0, A, A);
    do_rearm(); send(B, 0, "R6");
    send(C, 0, "R6");
    do_rearm(); send(A, 0, "R6"); send(A, 0, "R6");
    repeat (3) @(negedge clk);
    check(exp_id.size() == 0 && !detect, "R6 no partial match", detect, 0);

    // R8: a preamble drop empties the window
    cur_req = "R8";
    do_rearm();
    send(A, 0, "R8"); send(A, 0, "R8"); send(A, 0, "R8");
    @(negedge clk); preamble = 1'b0;
    send(B, 0, "R8");
    @(negedge clk); preamble = 1'b1;
    send(B, 0, "R8");
    repeat (3) @(negedge clk);
    check(exp_id.size() == 0 && !detect, "R8 split sequence ignored", detect, 0);
    send4(pk(A, A, A, B), 1, "R8 match after restart");

    // R11: symbol changes without a strobe are ignored
    cur_req = "R11";
    do_rearm();
    send(A, 0, "R11"); send(A, 0, "R11"); send(A, 0, "R11");
    @(negedge clk); sym = C;
    @(negedge clk); sym = D;
    @(negedge clk); sym = E;
    send(B, 1, "R11 strobe-only shifts");

    repeat (4) @(negedge clk);
    check(exp_id.size() == 0, "R2 all expected detects seen", exp_id.size(), 0);
    finish_run();
  end

endmodule